// File: doc/BRIEF.md
# Display Command Stream Decoder

This block sits at the front of a display controller and turns a byte-serial command stream into configuration state. Bytes arrive one per accepted cycle on a valid/ready pair. Every command starts with the prefix byte 0xAF followed by an opcode byte. Register-write commands land in a bank of 8-bit video registers. A lock/unlock handshake lets software stage a complete video mode in shadow copies and apply it in a single cycle, so the display never runs on half a mode.

The decoded state is presented as ready-to-use fields: blank mode, colour depth, two 24-bit framebuffer base pointers, a row of 16-bit timing words and the pixel-clock word. The timing words and the pixel-clock word assemble their two bytes in opposite orders. Framebuffer copy commands are parsed and reported as a one-cycle strobe that carries the source, pixel count and destination. A later stage does the copy. A lone trailing prefix is harmless. An opcode the block does not know raises a sticky error flag, and the parser then skips bytes until the next prefix.

Top module: `disp_cmd_decoder`

## Requirements
- R1: After reset, `blank_mode` is 0x07, the bank is unlocked, every other register output is zero, `cmd_error` and `copy_valid` are low, and `in_ready` is high.
- R2: While unlocked, a register write `AF 20 <addr> <data>` changes the matching output in the cycle after the data byte is accepted.
- R3: Writing 0x00 to address 0xFF locks the bank. While locked, register writes change no output. Writing 0xFF to address 0xFF unlocks the bank and applies every staged value together, visible in the cycle after that data byte.
- R4: Address 0x1F drives `blank_mode` and address 0x00 drives `color_depth`, each as a full byte.
- R5: `base_wide` is assembled from addresses 0x20 (bits 23:16), 0x21 (15:8) and 0x22 (7:0). `base_narrow` is assembled the same way from 0x26, 0x27 and 0x28.
- R6: Timing word k (bits 16k+15:16k of `timing_words`, k = 0..11) takes its high byte from address 0x01+2k and its low byte from 0x02+2k.
- R7: `pixel_clock` takes its low byte from address 0x1B and its high byte from 0x1C.
- R8: A copy command `AF 6A s2 s1 s0 n d2 d1 d0` raises `copy_valid` for exactly one cycle, in the cycle after d0 is accepted. It carries `copy_src` = {s2,s1,s0}, `copy_count` = n and `copy_dst` = {d2,d1,d0}.
- R9: A prefix byte received where an opcode is expected starts a new command. A lone 0xAF, with or without a following command, never sets `cmd_error`.
- R10: An opcode other than 0x20, 0x6A or 0xAF sets `cmd_error`, which stays set until reset. Bytes after that opcode are ignored until the next 0xAF.
- R11: A write to address 0xFF with data other than 0x00 or 0xFF neither locks nor unlocks the bank. Writes to addresses that have no field change no output.
- R12: Bytes presented while `in_valid` is low are not consumed, even when they equal 0xAF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| blank_mode | output | 8 | Committed blank-mode byte |
| color_depth | output | 8 | Committed colour-depth byte |
| base_wide | output | 24 | Base pointer of the 16-bpp framebuffer |
| base_narrow | output | 24 | Base pointer of the 8-bpp framebuffer |
| timing_words | output | 192 | Twelve 16-bit timing words, word k at bits 16k+15:16k |
| pixel_clock | output | 16 | Pixel clock in 5 kHz units |
| copy_valid | output | 1 | One-cycle strobe for a decoded copy command |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| cmd_error | output | 1 | Sticky flag for an unknown opcode |

## Verification
Register writes are sent in three settings: unlocked, locked and then released by an unlock, and with idle cycles that carry a prefix byte while `in_valid` is low. Together these separate immediate write-through from staged commit, and show that an unlock applies every staged byte in the same cycle rather than one byte at a time. Values with distinct high and low bytes go to the timing, pixel-clock and base-pointer addresses, so any swapped byte order shows up. Back-to-back copy commands with different fields feed a scoreboard. Lone prefixes, a doubled prefix, a malformed unlock value and an unknown opcode followed by a byte pattern that looks like a register write show that the parser resynchronises without stray writes.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    // Framing bytes
    localparam logic [7:0] CMD_PREFIX    = 8'hAF;
    localparam logic [7:0] OPC_REG_WRITE = 8'h20;
    localparam logic [7:0] OPC_FB_COPY   = 8'h6A;

    // Gate register: closing stages writes, opening commits them
    localparam logic [7:0] ADR_GATE   = 8'hFF;
    localparam logic [7:0] GATE_CLOSE = 8'h00;
    localparam logic [7:0] GATE_OPEN  = 8'hFF;

    // Register addresses whose position the display pipeline depends on
    localparam logic [7:0] ADR_DEPTH       = 8'h00;
    localparam logic [7:0] ADR_TIMING      = 8'h01;
    localparam logic [7:0] ADR_PCLK        = 8'h1B;
    localparam logic [7:0] ADR_BLANK       = 8'h1F;
    localparam logic [7:0] ADR_BASE_WIDE   = 8'h20;
    localparam logic [7:0] ADR_BASE_NARROW = 8'h26;

    localparam logic [7:0] BLANK_AT_RESET = 8'h07;

    typedef enum logic [2:0] {
        PS_HUNT,
        PS_OPCODE,
        PS_REG_ADDR,
        PS_REG_DATA,
        PS_COPY_ARG
    } parse_st_e;

    // Compact storage: only addresses that feed a field own a slot
    function automatic int slot_pclk(input int nt);
        return 1 + 2 * nt;
    endfunction

    function automatic int slot_blank(input int nt);
        return 3 + 2 * nt;
    endfunction

    function automatic int slot_wide(input int nt);
        return 4 + 2 * nt;
    endfunction

    function automatic int slot_narrow(input int nt, input int ab);
        return 4 + 2 * nt + ab;
    endfunction

    function automatic int slot_count(input int nt, input int ab);
        return 4 + 2 * nt + 2 * ab;
    endfunction

    // Returns the storage slot of a register address, or -1 when unmapped
    function automatic int slot_of(input logic [7:0] a, input int nt, input int ab);
        int ai;
        ai = int'(a);
        if (a == ADR_DEPTH) return 0;
        if (ai >= int'(ADR_TIMING) && ai < int'(ADR_TIMING) + 2 * nt)
            return 1 + ai - int'(ADR_TIMING);
        if (a == ADR_PCLK) return slot_pclk(nt);
        if (ai == int'(ADR_PCLK) + 1) return slot_pclk(nt) + 1;
        if (a == ADR_BLANK) return slot_blank(nt);
        if (ai >= int'(ADR_BASE_WIDE) && ai < int'(ADR_BASE_WIDE) + ab)
            return slot_wide(nt) + ai - int'(ADR_BASE_WIDE);
        if (ai >= int'(ADR_BASE_NARROW) && ai < int'(ADR_BASE_NARROW) + ab)
            return slot_narrow(nt, ab) + ai - int'(ADR_BASE_NARROW);
        return -1;
    endfunction

endpackage

// File: rtl/dcp_parser.sv
module dcp_parser
    import dcp_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [7:0]                in_data,
    output logic                      wr_en,
    output logic [7:0]                wr_addr,
    output logic [7:0]                wr_data,
    output logic                      copy_valid,
    output logic [8*ADDR_BYTES-1:0]   copy_src,
    output logic [7:0]                copy_count,
    output logic [8*ADDR_BYTES-1:0]   copy_dst,
    output logic                      cmd_error
);

    localparam int ADDR_W    = 8 * ADDR_BYTES;
    localparam int ARG_BYTES = 2 * ADDR_BYTES + 1;
    localparam int ARG_W     = 8 * (ARG_BYTES - 1);
    localparam int FULL_W    = 8 * ARG_BYTES;
    localparam int CNT_W     = $clog2(ARG_BYTES);

    typedef struct packed {
        parse_st_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [7:0]         addr;
        logic [ARG_W-1:0]   args;
        logic               err;
        logic               cp_v;
        logic [ADDR_W-1:0]  cp_src;
        logic [7:0]         cp_cnt;
        logic [ADDR_W-1:0]  cp_dst;
    } prs_t;

    prs_t q, d;
    logic [FULL_W-1:0] full_args;

    always_comb begin
        d         = q;
        d.cp_v    = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = q.addr;
        wr_data   = in_data;
        full_args = {q.args, in_data};
        if (in_valid) begin
            case (q.st)
                PS_HUNT: begin
                    if (in_data == CMD_PREFIX) d.st = PS_OPCODE;
                end
                PS_OPCODE: begin
                    if (in_data == OPC_REG_WRITE) begin
                        d.st = PS_REG_ADDR;
                    end else if (in_data == OPC_FB_COPY) begin
                        d.st  = PS_COPY_ARG;
                        d.cnt = '0;
                    end else if (in_data == CMD_PREFIX) begin
                        d.st = PS_OPCODE;
                    end else begin
                        d.err = 1'b1;
                        d.st  = PS_HUNT;
                    end
                end
                PS_REG_ADDR: begin
                    d.addr = in_data;
                    d.st   = PS_REG_DATA;
                end
                PS_REG_DATA: begin
                    wr_en = 1'b1;
                    d.st  = PS_HUNT;
                end
                PS_COPY_ARG: begin
                    if (q.cnt == CNT_W'(ARG_BYTES - 1)) begin
                        d.cp_v   = 1'b1;
                        d.cp_src = full_args[FULL_W-1 -: ADDR_W];
                        d.cp_cnt = full_args[ADDR_W +: 8];
                        d.cp_dst = full_args[ADDR_W-1:0];
                        d.st     = PS_HUNT;
                    end else begin
                        d.args = full_args[ARG_W-1:0];
                        d.cnt  = q.cnt + 1'b1;
                    end
                end
                default: d.st = PS_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= PS_HUNT;
            q.cnt    <= '0;
            q.addr   <= '0;
            q.args   <= '0;
            q.err    <= 1'b0;
            q.cp_v   <= 1'b0;
            q.cp_src <= '0;
            q.cp_cnt <= '0;
            q.cp_dst <= '0;
        end else begin
            q <= d;
        end
    end

    assign copy_valid = q.cp_v;
    assign copy_src   = q.cp_src;
    assign copy_count = q.cp_cnt;
    assign copy_dst   = q.cp_dst;
    assign cmd_error  = q.err;

    // R8
    copy_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cp_v |=> !q.cp_v);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(q.st) && $stable(q.cnt)));

endmodule

// File: rtl/dcp_shadow_bank.sv
module dcp_shadow_bank
    import dcp_pkg::*;
#(
    parameter int NUM_TIMING = 12,
    parameter int ADDR_BYTES = 3
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             wr_en,
    input  logic [7:0]                                       wr_addr,
    input  logic [7:0]                                       wr_data,
    output logic [8*slot_count(NUM_TIMING, ADDR_BYTES)-1:0]  vis_flat,
    output logic                                             locked
);

    localparam int NSLOT   = slot_count(NUM_TIMING, ADDR_BYTES);
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int S_BLANK = slot_blank(NUM_TIMING);
    localparam logic [8*NSLOT-1:0] RST_IMG =
        (8 * NSLOT)'(BLANK_AT_RESET) << (8 * S_BLANK);

    typedef struct packed {
        logic                   locked;
        logic [NSLOT-1:0][7:0]  shadow;
        logic [NSLOT-1:0][7:0]  vis;
    } bank_t;

    bank_t q, d;
    int slot;
    logic hit;
    logic [SLOT_W-1:0] hit_idx;
    logic gate_open;

    always_comb begin
        slot      = slot_of(wr_addr, NUM_TIMING, ADDR_BYTES);
        hit       = (slot >= 0);
        hit_idx   = SLOT_W'(slot);
        gate_open = wr_en && (wr_addr == ADR_GATE) && (wr_data == GATE_OPEN);
        d         = q;
        if (wr_en) begin
            if (wr_addr == ADR_GATE) begin
                if (wr_data == GATE_CLOSE) begin
                    d.locked = 1'b1;
                end else if (wr_data == GATE_OPEN) begin
                    d.locked = 1'b0;
                    d.vis    = q.shadow;
                end
            end else if (hit) begin
                d.shadow[hit_idx] = wr_data;
                if (!q.locked) d.vis[hit_idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.locked <= 1'b0;
            q.shadow <= RST_IMG;
            q.vis    <= RST_IMG;
        end else begin
            q <= d;
        end
    end

    assign vis_flat = q.vis;
    assign locked   = q.locked;

    // R2
    unlocked_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.locked && wr_en && hit) |=> (q.vis[$past(hit_idx)] == $past(wr_data)));

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.locked && !gate_open) |=> $stable(q.vis));

    // R3
    unlock_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |=> (q.vis == $past(q.shadow) && !q.locked));

endmodule

// File: rtl/dcp_view.sv
module dcp_view
    import dcp_pkg::*;
#(
    parameter int NUM_TIMING = 12,
    parameter int ADDR_BYTES = 3
) (
    input  logic [8*slot_count(NUM_TIMING, ADDR_BYTES)-1:0] vis_flat,
    output logic [7:0]                   blank_mode,
    output logic [7:0]                   color_depth,
    output logic [8*ADDR_BYTES-1:0]      base_wide,
    output logic [8*ADDR_BYTES-1:0]      base_narrow,
    output logic [16*NUM_TIMING-1:0]     timing_words,
    output logic [15:0]                  pixel_clock
);

    localparam int ADDR_W   = 8 * ADDR_BYTES;
    localparam int S_TIMING = 1;
    localparam int S_PCLK   = slot_pclk(NUM_TIMING);
    localparam int S_BLANK  = slot_blank(NUM_TIMING);
    localparam int S_WIDE   = slot_wide(NUM_TIMING);
    localparam int S_NARROW = slot_narrow(NUM_TIMING, ADDR_BYTES);

    assign color_depth = vis_flat[0 +: 8];
    assign blank_mode  = vis_flat[8*S_BLANK +: 8];
    // Pixel clock: first address holds the low byte
    assign pixel_clock = {vis_flat[8*(S_PCLK+1) +: 8], vis_flat[8*S_PCLK +: 8]};

    // Timing words: first address holds the high byte
    for (genvar k = 0; k < NUM_TIMING; k++) begin : g_timing
        assign timing_words[16*k +: 16] = {vis_flat[8*(S_TIMING+2*k) +: 8],
                                           vis_flat[8*(S_TIMING+2*k+1) +: 8]};
    end

    // Base pointers: lowest address holds the most significant byte
    for (genvar j = 0; j < ADDR_BYTES; j++) begin : g_base
        assign base_wide[ADDR_W-1-8*j -: 8]   = vis_flat[8*(S_WIDE+j) +: 8];
        assign base_narrow[ADDR_W-1-8*j -: 8] = vis_flat[8*(S_NARROW+j) +: 8];
    end

endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
    import dcp_pkg::*;
#(
    parameter int NUM_TIMING = 12,
    parameter int ADDR_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    output logic                        in_ready,
    output logic [7:0]                  blank_mode,
    output logic [7:0]                  color_depth,
    output logic [8*ADDR_BYTES-1:0]     base_wide,
    output logic [8*ADDR_BYTES-1:0]     base_narrow,
    output logic [16*NUM_TIMING-1:0]    timing_words,
    output logic [15:0]                 pixel_clock,
    output logic                        copy_valid,
    output logic [8*ADDR_BYTES-1:0]     copy_src,
    output logic [7:0]                  copy_count,
    output logic [8*ADDR_BYTES-1:0]     copy_dst,
    output logic                        cmd_error
);

    localparam int NSLOT = slot_count(NUM_TIMING, ADDR_BYTES);

    logic             wr_en;
    logic [7:0]       wr_addr;
    logic [7:0]       wr_data;
    logic [8*NSLOT-1:0] vis_flat;
    logic             bank_locked;

    // Every byte is consumed in the cycle it is offered
    assign in_ready = 1'b1;

    dcp_parser #(.ADDR_BYTES(ADDR_BYTES)) u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .copy_valid (copy_valid),
        .copy_src   (copy_src),
        .copy_count (copy_count),
        .copy_dst   (copy_dst),
        .cmd_error  (cmd_error)
    );

    dcp_shadow_bank #(.NUM_TIMING(NUM_TIMING), .ADDR_BYTES(ADDR_BYTES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .vis_flat (vis_flat),
        .locked   (bank_locked)
    );

    dcp_view #(.NUM_TIMING(NUM_TIMING), .ADDR_BYTES(ADDR_BYTES)) u_view (
        .vis_flat     (vis_flat),
        .blank_mode   (blank_mode),
        .color_depth  (color_depth),
        .base_wide    (base_wide),
        .base_narrow  (base_narrow),
        .timing_words (timing_words),
        .pixel_clock  (pixel_clock)
    );

    // R1
    reset_unlocked_chk: assert property (@(posedge clk)
        !rst_n |=> (!bank_locked && blank_mode == BLANK_AT_RESET && !cmd_error));

endmodule

// File: tb/disp_cmd_decoder_bench.sv
`timescale 1ns/1ps
module disp_cmd_decoder_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = 8'h00;
    logic         in_ready;
    logic [7:0]   blank_mode;
    logic [7:0]   color_depth;
    logic [23:0]  base_wide;
    logic [23:0]  base_narrow;
    logic [191:0] timing_words;
    logic [15:0]  pixel_clock;
    logic         copy_valid;
    logic [23:0]  copy_src;
    logic [7:0]   copy_count;
    logic [23:0]  copy_dst;
    logic         cmd_error;

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [23:0] s;
        logic [7:0]  c;
        logic [23:0] d;
    } cp_item_t;

    cp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    disp_cmd_decoder u_disp_cmd_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .blank_mode   (blank_mode),
        .color_depth  (color_depth),
        .base_wide    (base_wide),
        .base_narrow  (base_narrow),
        .timing_words (timing_words),
        .pixel_clock  (pixel_clock),
        .copy_valid   (copy_valid),
        .copy_src     (copy_src),
        .copy_count   (copy_count),
        .copy_dst     (copy_dst),
        .cmd_error    (cmd_error)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    // Idle cycles carry a prefix byte with valid low
    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 8'hAF;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        put(8'hAF); put(8'h20); put(a); put(v);
    endtask

    task automatic fb_copy(input logic [23:0] s, input logic [7:0] c, input logic [23:0] d);
        exp_q.push_back({s, c, d});
        put(8'hAF); put(8'h6A);
        put(s[23:16]); put(s[15:8]); put(s[7:0]);
        put(c);
        put(d[23:16]); put(d[15:8]); put(d[7:0]);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Scoreboard monitor for copy strobes (R8)
    always @(negedge clk) begin
        cp_item_t e;
        if (rst_n && copy_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8 unexpected copy strobe: actual %h expected none",
                         {copy_src, copy_count, copy_dst});
            end else begin
                e = exp_q.pop_front();
                chk("R8 copy fields", {8'h00, copy_src, copy_count, copy_dst}, {8'h00, e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        gap(1);

        // R1 reset state
        chk("R1 blank", blank_mode, 8'h07);
        chk("R1 depth", color_depth, 8'h00);
        chk("R1 bases", {base_wide, base_narrow}, 48'h0);
        chk("R1 timing/pclk", {timing_words[63:0] | timing_words[191:128], pixel_clock}, 80'h0);
        chk("R1 flags", {in_ready, cmd_error, copy_valid}, 3'b100);

        // R2 / R4 unlocked writes land right after the data byte
        wr(8'h1F, 8'h01);
        chk("R2 not before data edge", blank_mode, 8'h07);
        gap(1);
        chk("R2 R4 blank write", blank_mode, 8'h01);
        wr(8'h00, 8'h01); gap(1);
        chk("R4 depth write", color_depth, 8'h01);

        // R12 bytes with valid low are not consumed
        put(8'hAF); put(8'h20); gap(3); put(8'h1F); gap(2); put(8'h05); gap(1);
        chk("R12 gapped write", blank_mode, 8'h05);

        // R3 locked staging, then one-cycle commit
        wr(8'hFF, 8'h00);
        wr(8'h1F, 8'h00);
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
        wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
        wr(8'h01, 8'h12); wr(8'h02, 8'h34);
        wr(8'h17, 8'hAB); wr(8'h18, 8'hCD);
        wr(8'h1B, 8'h78); wr(8'h1C, 8'h56);
        gap(2);
        chk("R3 blank held while locked", blank_mode, 8'h05);
        chk("R3 bases held while locked", {base_wide, base_narrow}, 48'h0);
        chk("R3 pclk held while locked", pixel_clock, 16'h0);
        wr(8'hFF, 8'hFF);
        chk("R3 no commit before unlock edge", base_wide, 24'h0);
        gap(1);
        chk("R3 blank committed", blank_mode, 8'h00);
        chk("R5 wide base", base_wide, 24'h123456);
        chk("R5 narrow base", base_narrow, 24'hABCDEF);
        chk("R6 timing word 0", timing_words[15:0], 16'h1234);
        chk("R6 timing word 11", timing_words[191:176], 16'hABCD);
        chk("R7 pixel clock", pixel_clock, 16'h5678);

        // R11 malformed gate value and unmapped address
        wr(8'hFF, 8'h5A);
        wr(8'h1F, 8'h01); gap(1);
        chk("R11 gate 0x5A leaves bank unlocked", blank_mode, 8'h01);
        wr(8'h40, 8'h99); gap(1);
        chk("R11 unmapped write", {color_depth, blank_mode, base_wide, pixel_clock},
            {8'h01, 8'h01, 24'h123456, 16'h5678});

        // R8 back-to-back copies, one-cycle strobe
        fb_copy(24'h010203, 8'h10, 24'h040506);
        fb_copy(24'hA0B0C0, 8'hFF, 24'h0D0E0F);
        gap(1);
        chk("R8 strobe high after last byte", copy_valid, 1'b1);
        gap(1);
        chk("R8 strobe lasts one cycle", copy_valid, 1'b0);

        // R9 lone and doubled prefixes
        put(8'hAF); gap(3);
        chk("R9 lone prefix", cmd_error, 1'b0);
        put(8'hAF); wr(8'h1F, 8'h07); gap(1);
        chk("R9 doubled prefix write", {cmd_error, blank_mode}, {1'b0, 8'h07});

        // R10 unknown opcode, then look-alike bytes ignored
        put(8'hAF); put(8'h33); put(8'h20); put(8'h1F); put(8'h01); gap(1);
        chk("R10 error raised, trailing bytes ignored", {cmd_error, blank_mode}, {1'b1, 8'h07});
        wr(8'h1F, 8'h00); gap(1);
        chk("R10 resync and sticky", {cmd_error, blank_mode}, {1'b1, 8'h00});

        gap(3);
        chk("R8 scoreboard drained", 64'(exp_q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule